// File: doc/BRIEF.md
# Six-Source Vectored Interrupt Controller

This block sits beside a small processor core. It owns the interrupt fields of the core's flag word and control word. It watches six request lines and picks one source when an interrupt is due. It then runs the entry sequence:

1. It sets the global mask.
2. It moves the stack pointer (register 31) down by one word and saves a return address in register 30.
3. It pushes that return address to memory through a single-word write port.
4. It redirects the program counter to the chosen source's vector.

The core's instruction fetch and bus logic stay outside the block. The core supplies the current stack pointer and program counter, strobes the flag write port when software writes the flag word, and marks instruction boundaries.

A check for an interrupt happens at two moments. The first is the cycle after a request line rises. The second is an instruction boundary that follows a software write that cleared the mask. The core may mark a boundary as inhibited, which defers the second kind of check. Software can never set the mask: only the entry sequence sets it.

Top module: `vic_top`

## Requirements
- R1: After reset, the flag view, the control view and every strobe output (spWrEn, linkWrEn, memWrReq, pcLoad) are 0.
- R2: A rising request line sets its latch, and a falling line clears it. In ctrlView the latches of sources 0..4 appear at bits 6..10 and the latch of source 5 at bit 16.
- R3: A flag write with bit 9..13 set clears latch 0..4, and with bit 17 set clears latch 5. If a line rises in the same cycle as a write that clears its latch, the latch ends at 0.
- R4: A flag write loads the enables from data bits 4..8 (sources 0..4) and bit 16 (source 5). The mask at flagView bit 3 is stored as 0 whatever data bit 3 holds. flagView shows the enables at those same positions.
- R5: Among the sources that are both latched and enabled, the highest-numbered one is serviced.
- R6: No interrupt is taken while the mask is 1, and a source whose enable is 0 is never taken.
- R7: In the take cycle, spWrEn pulses with spIn-4 and linkWrEn pulses with pcIn-2. From the next cycle the mask reads 1.
- R8: From the cycle after the take, memWrReq stays high with memAddr = spIn-4 and memData = pcIn-2 until memAck is seen. pcLoad stays low meanwhile.
- R9: In the cycle after memAck is accepted, pcLoad and linkWrEn pulse for one cycle with VEC_BASE + 16*source.
- R10: A flag write that clears a mask that was 1 records a re-check. The re-check runs at the next boundary with inhibit low, and the take happens in that same cycle if a source is active.
- R11: A boundary with inhibit high leaves the record in place. Once the re-check has run, the record is gone, and later boundaries check nothing.
- R12: A request rise triggers a check in the following cycle. Writing enables for a source that is already latched triggers no check by itself.
- R13: If a flag write falls in the take cycle, the mask ends at 1 and the entry sequence proceeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqReq | input | 6 | Request lines, bit n is source n |
| flagWrEn | input | 1 | Software write strobe for the flag word |
| flagWrData | input | 32 | Flag word being written |
| boundary | input | 1 | Marks an instruction boundary this cycle |
| inhibit | input | 1 | Interrupt check inhibited at this boundary |
| spIn | input | 32 | Current register 31 |
| pcIn | input | 32 | Current program counter |
| memAck | input | 1 | Push write accepted |
| flagView | output | 32 | Owned flag fields: mask bit 3, enables |
| ctrlView | output | 32 | Owned control fields: request latches |
| spWrEn | output | 1 | Write register 31 |
| spWrData | output | 32 | New register 31 value |
| linkWrEn | output | 1 | Write register 30 |
| linkWrData | output | 32 | New register 30 value |
| memWrReq | output | 1 | Push write request |
| memAddr | output | 32 | Push address |
| memData | output | 32 | Push data |
| pcLoad | output | 1 | Load program counter |
| pcLoadVal | output | 32 | Vector address |

## Verification
Two pairs of functions can land in the same cycle.

The first pair is a request rise and a software clear of the same latch. The bench raises a line in exactly the cycle that the flag write carries that line's clear bit. It then reads ctrlView one cycle later and expects the bit at 0.

The second pair is the take and a software flag write. The bench drives a flag write in the take cycle itself, which it identifies by the spWrEn pulse. It then expects the mask to read 1 and the push to go ahead.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC = 6;
  // field positions in the flag and control words
  localparam int MASK_POS = 3;
  localparam int EN_LO    = 4;
  localparam int EN_HI5   = 16;
  localparam int CLR_LO   = 9;
  localparam int CLR_HI5  = 17;
  localparam int LAT_LO   = 6;
  localparam int LAT_HI5  = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_VEC} vicState_t;

  typedef struct packed {
    logic take;
    logic push;
    logic vect;
  } vicStrobe_t;
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       flagWrEn,
  input  logic       maskBit,
  input  logic       anyRise,
  input  logic       anyActive,
  input  logic       boundary,
  input  logic       inhibit,
  input  logic       memAck,
  output vicStrobe_t strobe
);
  vicState_t state, stateNext;
  logic checkReq, rearmRec;
  logic runRearm, doCheck, isIdle, takeNow;

  assign isIdle   = (state == ST_IDLE);
  assign runRearm = rearmRec & boundary & ~inhibit;
  assign doCheck  = checkReq | runRearm;
  assign takeNow  = isIdle & doCheck & ~maskBit & anyActive;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (takeNow) stateNext = ST_PUSH;
      ST_PUSH: if (memAck)  stateNext = ST_VEC;
      ST_VEC:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      checkReq <= 1'b0;
      rearmRec <= 1'b0;
    end else begin
      state    <= stateNext;
      // an idle cycle consumes the pending immediate check
      checkReq <= anyRise | (checkReq & ~isIdle);
      rearmRec <= (flagWrEn & maskBit) | (rearmRec & ~runRearm);
    end
  end

  assign strobe.take = takeNow;
  assign strobe.push = (state == ST_PUSH);
  assign strobe.vect = (state == ST_VEC);
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int            DW         = 32,
  parameter logic [DW-1:0] VEC_BASE   = 32'h0001_0000,
  parameter int            VEC_STRIDE = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] irqReq,
  input  logic            flagWrEn,
  input  logic [DW-1:0]   flagWrData,
  input  logic [DW-1:0]   spIn,
  input  logic [DW-1:0]   pcIn,
  input  vicStrobe_t      strobe,
  output logic            maskBit,
  output logic            anyRise,
  output logic            anyActive,
  output logic [DW-1:0]   flagView,
  output logic [DW-1:0]   ctrlView,
  output logic            spWrEn,
  output logic [DW-1:0]   spWrData,
  output logic            linkWrEn,
  output logic [DW-1:0]   linkWrData,
  output logic            memWrReq,
  output logic [DW-1:0]   memAddr,
  output logic [DW-1:0]   memData,
  output logic            pcLoad,
  output logic [DW-1:0]   pcLoadVal
);
  localparam int SW = $clog2(NSRC);

  logic [NSRC-1:0] reqPrev, latch, enable, rise, fall, clrBits, active;
  logic [SW-1:0]   winner;
  logic [DW-1:0]   savedSp, savedRet, savedVec, newSp, retAddr;
  logic            unusedFlagBits;

  assign unusedFlagBits = ^{flagWrData[DW-1:18], flagWrData[15:14], flagWrData[3:0]};

  assign rise    = irqReq & ~reqPrev;
  assign fall    = ~irqReq & reqPrev;
  assign clrBits = flagWrEn ? {flagWrData[CLR_HI5], flagWrData[CLR_LO +: NSRC-1]} : '0;
  assign active  = latch & enable;
  assign anyRise   = |rise;
  assign anyActive = |active;

  // ascending scan so the highest set index wins
  always_comb begin
    winner = '0;
    for (int i = 0; i < NSRC; i++)
      if (active[i]) winner = SW'(i);
  end

  assign newSp   = spIn - DW'(4);
  assign retAddr = pcIn - DW'(2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqPrev  <= '0;
      latch    <= '0;
      enable   <= '0;
      maskBit  <= 1'b0;
      savedSp  <= '0;
      savedRet <= '0;
      savedVec <= '0;
    end else begin
      reqPrev <= irqReq;
      latch   <= (latch | rise) & ~fall & ~clrBits;
      if (flagWrEn)
        enable <= {flagWrData[EN_HI5], flagWrData[EN_LO +: NSRC-1]};
      if (strobe.take)
        maskBit <= 1'b1;
      else if (flagWrEn)
        maskBit <= 1'b0;
      if (strobe.take) begin
        savedSp  <= newSp;
        savedRet <= retAddr;
        savedVec <= VEC_BASE + DW'(VEC_STRIDE) * DW'(winner);
      end
    end
  end

  always_comb begin
    flagView = '0;
    flagView[MASK_POS]            = maskBit;
    flagView[EN_LO +: NSRC-1]     = enable[NSRC-2:0];
    flagView[EN_HI5]              = enable[NSRC-1];
    ctrlView = '0;
    ctrlView[LAT_LO +: NSRC-1]    = latch[NSRC-2:0];
    ctrlView[LAT_HI5]             = latch[NSRC-1];
  end

  assign spWrEn     = strobe.take;
  assign spWrData   = newSp;
  assign linkWrEn   = strobe.take | strobe.vect;
  assign linkWrData = strobe.vect ? savedVec : retAddr;
  assign memWrReq   = strobe.push;
  assign memAddr    = savedSp;
  assign memData    = savedRet;
  assign pcLoad     = strobe.vect;
  assign pcLoadVal  = savedVec;
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int            DW         = 32,
  parameter logic [DW-1:0] VEC_BASE   = 32'h0001_0000,
  parameter int            VEC_STRIDE = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [5:0]    irqReq,
  input  logic          flagWrEn,
  input  logic [DW-1:0] flagWrData,
  input  logic          boundary,
  input  logic          inhibit,
  input  logic [DW-1:0] spIn,
  input  logic [DW-1:0] pcIn,
  input  logic          memAck,
  output logic [DW-1:0] flagView,
  output logic [DW-1:0] ctrlView,
  output logic          spWrEn,
  output logic [DW-1:0] spWrData,
  output logic          linkWrEn,
  output logic [DW-1:0] linkWrData,
  output logic          memWrReq,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memData,
  output logic          pcLoad,
  output logic [DW-1:0] pcLoadVal
);
  vicStrobe_t strobe;
  logic maskBit, anyRise, anyActive;

  vic_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .flagWrEn(flagWrEn), .maskBit(maskBit),
    .anyRise(anyRise), .anyActive(anyActive), .boundary(boundary),
    .inhibit(inhibit), .memAck(memAck), .strobe(strobe)
  );

  vic_datapath #(.DW(DW), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) uData (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .flagWrEn(flagWrEn),
    .flagWrData(flagWrData), .spIn(spIn), .pcIn(pcIn), .strobe(strobe),
    .maskBit(maskBit), .anyRise(anyRise), .anyActive(anyActive),
    .flagView(flagView), .ctrlView(ctrlView), .spWrEn(spWrEn),
    .spWrData(spWrData), .linkWrEn(linkWrEn), .linkWrData(linkWrData),
    .memWrReq(memWrReq), .memAddr(memAddr), .memData(memData),
    .pcLoad(pcLoad), .pcLoadVal(pcLoadVal)
  );
endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          flagWrEn,
  input logic          memAck,
  input logic [DW-1:0] flagView,
  input logic          spWrEn,
  input logic [DW-1:0] spWrData,
  input logic          memWrReq,
  input logic [DW-1:0] memAddr,
  input logic [DW-1:0] memData,
  input logic          pcLoad
);
  a_r6_no_take_masked: assert property (@(posedge clk) disable iff (!rstN)
    flagView[3] |-> !spWrEn);

  a_r7_take_sets_mask: assert property (@(posedge clk) disable iff (!rstN)
    spWrEn |=> flagView[3] && memWrReq);

  a_r8_push_addr: assert property (@(posedge clk) disable iff (!rstN)
    spWrEn |=> memAddr == $past(spWrData));

  a_r8_push_hold: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq && !memAck |=> memWrReq && $stable(memAddr) && $stable(memData));

  a_r8_no_pc_during_push: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq |-> !pcLoad);

  a_r9_pc_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    memWrReq && memAck |=> pcLoad);

  a_r9_pc_single: assert property (@(posedge clk) disable iff (!rstN)
    pcLoad |=> !pcLoad);

  a_r4_write_clears_mask: assert property (@(posedge clk) disable iff (!rstN)
    flagWrEn && !spWrEn |=> !flagView[3]);
endmodule

bind vic_top vic_checker #(.DW(DW)) uChk (
  .clk(clk), .rstN(rstN), .flagWrEn(flagWrEn), .memAck(memAck),
  .flagView(flagView), .spWrEn(spWrEn), .spWrData(spWrData),
  .memWrReq(memWrReq), .memAddr(memAddr), .memData(memData), .pcLoad(pcLoad)
);

// File: tb/vic_top_test.sv
`timescale 1ns/1ps
module vic_top_test;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [31:0] SP0  = 32'h0000_1000;
  localparam logic [31:0] PC0  = 32'h0000_2000;

  logic clk = 1'b0;
  logic rstN;
  logic [5:0] irqReq;
  logic flagWrEn, boundary, inhibit, memAck;
  logic [31:0] flagWrData, spIn, pcIn;
  logic [31:0] flagView, ctrlView, spWrData, linkWrData, memAddr, memData, pcLoadVal;
  logic spWrEn, linkWrEn, memWrReq, pcLoad;
  int nChecks = 0, nFails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vic_top uut (
    .clk(clk), .rstN(rstN), .irqReq(irqReq), .flagWrEn(flagWrEn),
    .flagWrData(flagWrData), .boundary(boundary), .inhibit(inhibit),
    .spIn(spIn), .pcIn(pcIn), .memAck(memAck), .flagView(flagView),
    .ctrlView(ctrlView), .spWrEn(spWrEn), .spWrData(spWrData),
    .linkWrEn(linkWrEn), .linkWrData(linkWrData), .memWrReq(memWrReq),
    .memAddr(memAddr), .memData(memData), .pcLoad(pcLoad), .pcLoadVal(pcLoadVal)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(posedge clk); #1;
  endtask

  task automatic writeFlags(input logic [31:0] d);
    flagWrEn = 1'b1; flagWrData = d;
    nxt();
    flagWrEn = 1'b0; flagWrData = '0;
  endtask

  // called in the take cycle, after inputs have settled
  task automatic doEntry(input int src, input int ackDelay);
    chk("R7 spWrEn", 32'(spWrEn), 1);
    chk("R7 spWrData", spWrData, SP0 - 4);
    chk("R7 linkWrEn", 32'(linkWrEn), 1);
    chk("R7 linkWrData", linkWrData, PC0 - 2);
    nxt(); boundary = 1'b0; inhibit = 1'b0; #1;
    chk("R7 mask set", 32'(flagView[3]), 1);
    chk("R8 memWrReq", 32'(memWrReq), 1);
    chk("R8 memAddr", memAddr, SP0 - 4);
    chk("R8 memData", memData, PC0 - 2);
    chk("R8 no pcLoad", 32'(pcLoad), 0);
    for (int k = 0; k < ackDelay; k++) begin
      nxt();
      chk("R8 hold req", 32'(memWrReq), 1);
      chk("R8 hold no pcLoad", 32'(pcLoad), 0);
    end
    memAck = 1'b1;
    nxt();
    memAck = 1'b0; #1;
    chk("R9 pcLoad", 32'(pcLoad), 1);
    chk("R5 R9 pcLoadVal", pcLoadVal, BASE + 32'(16 * src));
    chk("R9 linkWrEn", 32'(linkWrEn), 1);
    chk("R9 linkWrData", linkWrData, BASE + 32'(16 * src));
    nxt();
    chk("R9 pcLoad single", 32'(pcLoad), 0);
  endtask

  task automatic testReset();
    chk("R1 flagView", flagView, 0);
    chk("R1 ctrlView", ctrlView, 0);
    chk("R1 strobes", {28'b0, spWrEn, linkWrEn, memWrReq, pcLoad}, 0);
  endtask

  task automatic testLatch();
    irqReq[2] = 1'b1; nxt();
    chk("R2 latch src2 bit8", ctrlView, 32'h0000_0100);
    irqReq[5] = 1'b1; nxt();
    chk("R2 latch src5 bit16", ctrlView, 32'h0001_0100);
    chk("R6 disabled not taken", 32'(spWrEn), 0);
    irqReq[2] = 1'b0; nxt();
    chk("R2 fall clears", ctrlView, 32'h0001_0000);
    irqReq = '0; nxt();
  endtask

  task automatic testClear();
    irqReq[0] = 1'b1; irqReq[5] = 1'b1; nxt();
    chk("R3 latched", ctrlView, 32'h0001_0040);
    writeFlags(32'h0002_0200); #1;
    chk("R3 clear bits", ctrlView, 32'h0);
    irqReq = '0; nxt();
    irqReq[1] = 1'b1;
    writeFlags(32'h0000_0400); #1;
    chk("R3 clear beats rise", ctrlView, 32'h0);
    irqReq = '0; nxt();
  endtask

  task automatic testEnables();
    writeFlags(32'h0001_01F8); #1;
    chk("R4 enables, mask not set", flagView, 32'h0001_01F0);
  endtask

  task automatic testPriority();
    irqReq[1] = 1'b1; irqReq[3] = 1'b1; nxt();
    doEntry(3, 2);
    irqReq = '0; nxt();
  endtask

  task automatic testMaskedAndRearm();
    irqReq[4] = 1'b1; nxt();
    chk("R6 masked latch", ctrlView, 32'h0000_0400);
    chk("R6 masked no take", 32'(spWrEn), 0);
    nxt();
    chk("R6 masked no take later", 32'(spWrEn), 0);
    writeFlags(32'h0001_01F8); #1;
    chk("R10 mask cleared", flagView, 32'h0001_01F0);
    chk("R10 no take before boundary", 32'(spWrEn), 0);
    boundary = 1'b1; inhibit = 1'b1; #1;
    chk("R11 inhibited boundary", 32'(spWrEn), 0);
    nxt();
    inhibit = 1'b0; #1;
    chk("R10 R11 record kept, taken at boundary", 32'(spWrEn), 1);
    doEntry(4, 0);
    irqReq = '0; nxt();
  endtask

  task automatic testRecordCleared();
    writeFlags(32'h0);
    irqReq[2] = 1'b1; nxt();
    chk("R12 latched while disabled", ctrlView, 32'h0000_0100);
    chk("R12 no take disabled", 32'(spWrEn), 0);
    boundary = 1'b1; #1;
    chk("R11 rearm runs, nothing active", 32'(spWrEn), 0);
    nxt();
    boundary = 1'b0;
    writeFlags(32'h0001_01F0);
    boundary = 1'b1; #1;
    chk("R11 R12 no check after record used", 32'(spWrEn), 0);
    nxt();
    boundary = 1'b0;
    irqReq[0] = 1'b1; nxt();
    doEntry(2, 1);
    irqReq = '0; nxt();
  endtask

  task automatic testWriteDuringTake();
    writeFlags(32'h0001_01F0);
    irqReq[5] = 1'b1; nxt();
    flagWrEn = 1'b1; flagWrData = 32'h0001_01F0; #1;
    chk("R13 take cycle", 32'(spWrEn), 1);
    nxt();
    flagWrEn = 1'b0; flagWrData = '0; #1;
    chk("R13 mask stays set", 32'(flagView[3]), 1);
    chk("R13 push proceeds", 32'(memWrReq), 1);
    memAck = 1'b1; nxt();
    memAck = 1'b0; #1;
    chk("R13 vector src5", pcLoadVal, BASE + 32'h50);
    chk("R13 pcLoad", 32'(pcLoad), 1);
    irqReq = '0; nxt();
  endtask

  initial begin
    rstN = 1'b0; irqReq = '0; flagWrEn = 1'b0; flagWrData = '0;
    boundary = 1'b0; inhibit = 1'b0; memAck = 1'b0; spIn = SP0; pcIn = PC0;
    repeat (3) nxt();
    rstN = 1'b1; nxt();
    testReset();
    testLatch();
    testClear();
    testEnables();
    testPriority();
    testMaskedAndRearm();
    testRecordCleared();
    testWriteDuringTake();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #40000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule